// File: doc/BRIEF.md
# Digitally Trimmed One-Second Tick Generator

This block turns a stream of oscillator-cycle pulses from a 32,768 Hz source into a one-second tick. It also applies a slow digital rate correction, so that a crystal which runs slightly fast or slightly slow still keeps accurate time over the long run. The correction never touches the divider ratio of ordinary seconds. Instead, a small number of selected seconds are made shorter or longer by a fixed amount of oscillator cycles.

The correction repeats over a window of 64 minutes. A 5-bit magnitude N picks how many minutes at the start of that window carry one altered second. A sign bit picks the direction. Positive correction removes 256 cycles from the altered second, which is worth about +4.068 ppm per step. Negative correction adds 128 cycles, worth about -2.034 ppm per step. Because N is at most 31, at most 62 minutes of the window are ever touched.

The tick drives a downstream seconds counter. The index of the current minute within the window is brought out for observation. A stop input freezes the divider.

Top module: `cal_corrector`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, sec_tick is 0 and min_idx is 0. The first second after reset always has the nominal length, because the correction setting held in reset is magnitude 0.
- R2: Only clock cycles with osc_en high and stop low count as oscillator pulses. Cycles with osc_en low or stop high leave the divider unchanged and never produce a tick.
- R3: A second that is not altered lasts NOM_CYC pulses (32,768 by default). With magnitude 0, every second has this length whatever the sign bit holds.
- R4: With cal_sign = 1 (speed up), an altered second lasts NOM_CYC - FAST_CUT pulses (32,768 - 256 by default).
- R5: With cal_sign = 0 (slow down), an altered second lasts NOM_CYC + SLOW_ADD pulses (32,768 + 128 by default).
- R6: The altered second is second 0 of minute m, for each minute m of the window with m < 2*cal_mag. All other seconds are unaltered. With magnitude 31, minutes 0 to 61 are altered and minutes 62 and 63 are not.
- R7: min_idx holds the minute of the window in which the current second lies, counting 0 to 63. It changes only in the cycle in which sec_tick is high, at the end of the last second of a minute (second SEC_PER_MIN-1, 59 by default), and it wraps from 63 to 0.
- R8: cal_mag and cal_sign are sampled once, at the pulse that ends the previous second. A change made while a second is running has no effect on the length of that second.
- R9: sec_tick is high for exactly one clock cycle. That cycle follows the clock edge that counted the last pulse of the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle pulse per oscillator cycle |
| stop | input | 1 | Freezes the divider while high |
| cal_mag | input | 5 | Correction magnitude N (0 to 31) |
| cal_sign | input | 1 | 1 = shorten altered seconds, 0 = lengthen them |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| min_idx | output | 6 | Minute index inside the 64-minute window |

## Verification
Each tick-to-tick interval is measured and compared with the length predicted from that second's position in the window. The runs use magnitude 0 with both signs, a small magnitude with each sign, and magnitude 31 over a full window. Between them, these separate an untrimmed divider, the wrong sign direction, an off-by-one in the 2N minute limit, and the edge minutes 61 and 62. Further runs pause the divider with stop, thin out osc_en, and change the setting partway through a second. These show that only real pulses are counted and that the setting is taken only at the start of each second.

// File: rtl/cal_pkg.sv
package cal_pkg;
    // Direction of the rate correction applied to an altered second.
    typedef enum logic {
        DIR_SLOW = 1'b0,   // lengthen the altered second
        DIR_FAST = 1'b1    // shorten the altered second
    } cal_dir_e;
endpackage

// File: rtl/cal_len_sel.sv
// Chooses the pulse count of the second that is about to start.
module cal_len_sel
    import cal_pkg::*;
#(
    parameter int NOM_CYC  = 32768,
    parameter int FAST_CUT = 256,
    parameter int SLOW_ADD = 128,
    parameter int SW       = 6,
    parameter int MW       = 6,
    parameter int CW       = 16
) (
    input  logic [SW-1:0] sec_nx,
    input  logic [MW-1:0] min_nx,
    input  logic [4:0]    mag,
    input  logic          sign,
    output logic [CW-1:0] len
);
    logic     in_window;
    cal_dir_e dir;

    always_comb begin
        dir       = cal_dir_e'(sign);
        in_window = (sec_nx == '0) && (int'(min_nx) < (int'(mag) * 2));
        if (!in_window) begin
            len = CW'(NOM_CYC);
        end else if (dir == DIR_FAST) begin
            len = CW'(NOM_CYC - FAST_CUT);
        end else begin
            len = CW'(NOM_CYC + SLOW_ADD);
        end
    end
endmodule

// File: rtl/cal_time_idx.sv
// Second-of-minute and minute-of-window position counters.
module cal_time_idx #(
    parameter int SEC_PER_MIN = 60,
    parameter int MIN_PER_WIN = 64,
    parameter int SW          = 6,
    parameter int MW          = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [SW-1:0] sec_nx,
    output logic [MW-1:0] min_nx,
    output logic [MW-1:0] min_cur
);
    typedef struct packed {
        logic [SW-1:0] sec;
        logic [MW-1:0] mn;
    } idx_t;

    idx_t idx_q, idx_d, succ;

    always_comb begin
        succ = idx_q;
        if (idx_q.sec == SW'(SEC_PER_MIN - 1)) begin
            succ.sec = '0;
            succ.mn  = (idx_q.mn == MW'(MIN_PER_WIN - 1)) ? '0 : idx_q.mn + MW'(1);
        end else begin
            succ.sec = idx_q.sec + SW'(1);
        end
        idx_d = adv ? succ : idx_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign sec_nx  = succ.sec;
    assign min_nx  = succ.mn;
    assign min_cur = idx_q.mn;
endmodule

// File: rtl/cal_corrector.sv
// One-second tick generator with periodic whole-second rate correction.
module cal_corrector #(
    parameter int NOM_CYC     = 32768,
    parameter int FAST_CUT    = 256,
    parameter int SLOW_ADD    = 128,
    parameter int SEC_PER_MIN = 60,
    parameter int MIN_PER_WIN = 64,
    localparam int CW = $clog2(NOM_CYC + SLOW_ADD + 1),
    localparam int SW = $clog2(SEC_PER_MIN),
    localparam int MW = $clog2(MIN_PER_WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          osc_en,
    input  logic          stop,
    input  logic [4:0]    cal_mag,
    input  logic          cal_sign,
    output logic          sec_tick,
    output logic [MW-1:0] min_idx
);
    typedef struct packed {
        logic [CW-1:0] cnt;   // pulses counted in the current second
        logic [CW-1:0] len;   // pulse count of the current second
        logic          tick;
    } div_t;

    div_t          div_q, div_d;
    logic          pulse;
    logic          last;
    logic [SW-1:0] sec_nx;
    logic [MW-1:0] min_nx;
    logic [CW-1:0] len_nx;

    assign pulse = osc_en && !stop;
    assign last  = pulse && (div_q.cnt == div_q.len - CW'(1));

    cal_time_idx #(
        .SEC_PER_MIN (SEC_PER_MIN),
        .MIN_PER_WIN (MIN_PER_WIN),
        .SW          (SW),
        .MW          (MW)
    ) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (last),
        .sec_nx  (sec_nx),
        .min_nx  (min_nx),
        .min_cur (min_idx)
    );

    cal_len_sel #(
        .NOM_CYC  (NOM_CYC),
        .FAST_CUT (FAST_CUT),
        .SLOW_ADD (SLOW_ADD),
        .SW       (SW),
        .MW       (MW),
        .CW       (CW)
    ) u_len (
        .sec_nx (sec_nx),
        .min_nx (min_nx),
        .mag    (cal_mag),
        .sign   (cal_sign),
        .len    (len_nx)
    );

    always_comb begin
        div_d      = div_q;
        div_d.tick = 1'b0;
        if (last) begin
            div_d.cnt  = '0;
            div_d.len  = len_nx;   // setting sampled here, once per second
            div_d.tick = 1'b1;
        end else if (pulse) begin
            div_d.cnt = div_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q.cnt  <= '0;
            div_q.len  <= CW'(NOM_CYC);
            div_q.tick <= 1'b0;
        end else begin
            div_q <= div_d;
        end
    end

    assign sec_tick = div_q.tick;
endmodule

// File: rtl/cal_corr_chk.sv
module cal_corr_chk #(
    parameter int MIN_PER_WIN = 64,
    parameter int MW          = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          osc_en,
    input logic          stop,
    input logic          sec_tick,
    input logic [MW-1:0] min_idx
);
    // R9: tick lasts one cycle
    p_tick_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R2: a stopped cycle cannot finish a second
    p_stop_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sec_tick);

    // R2: a cycle without an oscillator pulse cannot finish a second
    p_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !sec_tick);

    // R7: minute index moves only together with a tick
    p_min_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(min_idx) |-> sec_tick);

    // R7: minute index returns to 0 only from the last minute
    p_min_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(min_idx) && min_idx == '0) |-> $past(min_idx) == MW'(MIN_PER_WIN - 1));
endmodule

bind cal_corrector cal_corr_chk #(
    .MIN_PER_WIN (MIN_PER_WIN),
    .MW          (MW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .stop     (stop),
    .sec_tick (sec_tick),
    .min_idx  (min_idx)
);

// File: tb/sim_cal_corrector.sv
`timescale 1ns/1ps
module sim_cal_corrector;
    localparam int NOM  = 64;
    localparam int FAST = 8;
    localparam int SLOW = 4;
    localparam int SPM  = 4;
    localparam int MPW  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       stop = 1'b0;
    logic [4:0] cal_mag = '0;
    logic       cal_sign = 1'b0;
    logic       sec_tick;
    logic [5:0] min_idx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    cal_corrector #(
        .NOM_CYC (NOM), .FAST_CUT (FAST), .SLOW_ADD (SLOW),
        .SEC_PER_MIN (SPM), .MIN_PER_WIN (MPW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .osc_en (osc_en), .stop (stop),
        .cal_mag (cal_mag), .cal_sign (cal_sign),
        .sec_tick (sec_tick), .min_idx (min_idx)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected length of second s after reset, setting constant since reset.
    function automatic int exp_len(input int s, input int mag, input bit sgn);
        if (s == 0) return NOM;
        if ((s % SPM == 0) && (((s / SPM) % MPW) < 2 * mag))
            return sgn ? NOM - FAST : NOM + SLOW;
        return NOM;
    endfunction

    // Counts negedges until a tick is seen; toggle thins out osc_en.
    task automatic wait_tick(output int n, input bit toggle);
        n = 0;
        do begin
            @(negedge clk);
            if (toggle) osc_en = ~osc_en;
            n++;
        end while (!sec_tick && n < 3000);
        if (!sec_tick) chk(1'b0, "watchdog tick", n, 0);
    endtask

    task automatic do_reset(input int mag, input bit sgn);
        @(negedge clk);
        rst_n = 1'b0; osc_en = 1'b1; stop = 1'b0;
        cal_mag = 5'(mag); cal_sign = sgn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        int n;
        @(negedge clk);
        rst_n = 1'b0; osc_en = 1'b1; cal_mag = 5'd5; cal_sign = 1'b1;
        repeat (3) @(negedge clk);
        chk(sec_tick == 1'b0, "R1 tick in reset", int'(sec_tick), 0);
        chk(min_idx == 6'd0, "R1 min in reset", int'(min_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sec_tick == 1'b0 && min_idx == 6'd0, "R1 after release", int'(min_idx), 0);
        wait_tick(n, 1'b0);
        chk(n == NOM - 1, "R1 first second nominal", n, NOM - 1);
    endtask

    task automatic t_run(input int mag, input bit sgn, input int nsec,
                         input bit chk_min, input string req);
        int n;
        do_reset(mag, sgn);
        wait_tick(n, 1'b0);
        for (int k = 1; k <= nsec; k++) begin
            wait_tick(n, 1'b0);
            chk(n == exp_len(k, mag, sgn), req, n, exp_len(k, mag, sgn));
            if (chk_min)
                chk(int'(min_idx) == ((k + 1) / SPM) % MPW, "R7 minute index",
                    int'(min_idx), ((k + 1) / SPM) % MPW);
        end
    endtask

    task automatic t_stop;
        int n;
        do_reset(0, 1'b0);
        wait_tick(n, 1'b0);
        stop = 1'b1;
        repeat (50) @(negedge clk);
        stop = 1'b0;
        wait_tick(n, 1'b0);
        chk(n + 50 == NOM + 50, "R2 stop holds divider", n + 50, NOM + 50);
    endtask

    task automatic t_gaps;
        int n;
        do_reset(0, 1'b1);
        wait_tick(n, 1'b0);
        osc_en = 1'b0;
        wait_tick(n, 1'b1);
        chk(n == 2 * NOM, "R2 idle cycles not counted", n, 2 * NOM);
        osc_en = 1'b1;
    endtask

    task automatic t_midchange;
        int n;
        do_reset(0, 1'b1);
        wait_tick(n, 1'b0);                 // second 1 begins, magnitude 0
        repeat (10) @(negedge clk);
        cal_mag = 5'd1;                     // R8: takes effect from second 2
        wait_tick(n, 1'b0);
        chk(n + 10 == NOM, "R8 running second unchanged", n + 10, NOM);
        wait_tick(n, 1'b0);
        wait_tick(n, 1'b0);                 // second 4 (minute 1) begins
        chk(n == NOM, "R8 second 3 nominal", n, NOM);
        repeat (10) @(negedge clk);
        cal_mag = 5'd0;                     // R8: no effect on second 4
        wait_tick(n, 1'b0);
        chk(n + 10 == NOM - FAST, "R8 sampled at second start", n + 10, NOM - FAST);
        wait_tick(n, 1'b0);
        chk(n == NOM, "R8 new setting next second", n, NOM);
    endtask

    initial begin
        t_reset();
        t_run(0, 1'b1, 40, 1'b0, "R3 magnitude 0 fast sign");
        t_run(0, 1'b0, 40, 1'b0, "R3 magnitude 0 slow sign");
        t_run(3, 1'b1, 40, 1'b0, "R4 shortened second");
        t_run(3, 1'b0, 40, 1'b0, "R5 lengthened second");
        t_run(31, 1'b1, 262, 1'b1, "R6 window limit magnitude 31");
        t_run(1, 1'b0, 262, 1'b0, "R6 window limit magnitude 1");
        t_stop();
        t_gaps();
        t_midchange();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule